// File: doc/BRIEF.md
# Video/CPU DRAM Address Multiplexer

This block drives the eight multiplexed address lines of a DRAM array that is shared by two masters: a screen refresh path fed by a CRT controller (character memory address plus raster-line count) and a microprocessor. Each output line is a four-way selector. One select term tells whose cycle it is, taken directly from the video-cycle flag. The other select term tells whether the row or the column half of the address is presented.

The row/column select and the active-low column strobe are both produced here as delayed copies of the active-low row strobe. The select is the row strobe registered on the fast master clock, so it trails the strobe by one master period. The column strobe is the row strobe registered on the half-rate clock, so it trails by one or two master periods depending on the phase at which the row strobe moves. While the row strobe is high (precharge) the row half is presented, so the row address is settled before the strobe falls. For video cycles the row address interleaves the low raster-line bits below the low character-address bits, so successive scan lines of one character row hit different DRAM rows.

Top module: `vdram_addr_mux`

## Requirements
- R1: While reset is held low, cas_n is 1 and dram_addr shows the row half of the selected owner's address, whatever ras_n does.
- R2: With vid_cyc = 1 in row phase, dram_addr bits 2..0 are raster[2:0] and bits 7..3 are crtc_ma[4:0].
- R3: With vid_cyc = 1 in column phase, dram_addr bits 7..0 are crtc_ma[12:5].
- R4: With vid_cyc = 0 in row phase, dram_addr is cpu_addr[7:0].
- R5: With vid_cyc = 0 in column phase, dram_addr is cpu_addr[15:8].
- R6: A change of vid_cyc or of any address input reaches dram_addr without waiting for a clock edge.
- R7: The row/column phase is ras_n sampled on each rising clk_fast edge: after ras_n falls, column phase starts at the next rising clk_fast edge; after ras_n rises, row phase returns at the next rising clk_fast edge.
- R8: cas_n is ras_n sampled on each rising clk_half edge: after ras_n falls it goes low at the next rising clk_half edge, which is one or two clk_fast periods later.
- R9: After ras_n rises, cas_n returns to 1 at the next rising clk_half edge, so no later than the second rising clk_fast edge.
- R10: While ras_n has been high since the previous rising clk_fast edge, dram_addr shows the row half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Master clock; samples the row strobe to form the row/column select |
| clk_half | input | 1 | Half-rate clock, rising edges aligned to clk_fast rising edges; samples the row strobe to form cas_n |
| rst_n | input | 1 | Asynchronous active-low reset; forces row phase and cas_n high |
| ras_n | input | 1 | Active-low DRAM row strobe from the cycle scheduler |
| vid_cyc | input | 1 | 1 = current DRAM cycle belongs to the video path, 0 = CPU |
| crtc_ma | input | 13 | CRT controller character memory address |
| raster | input | 3 | CRT controller raster-line address, low bits |
| cpu_addr | input | 16 | Microprocessor address |
| dram_addr | output | 8 | Multiplexed DRAM address |
| cas_n | output | 1 | Active-low DRAM column strobe |

## Verification
A single one is walked across every bit of the CPU address, the character address and the raster count in each of the four owner/phase combinations, which separates a swapped, shifted or wrongly sourced field from a correct one, including bits that must not appear in a given half. A dense mixed pattern is applied and vid_cyc is toggled with the other inputs held, showing that ownership switches in the same cycle. The row strobe is dropped and raised both just after a half-rate edge and halfway between two, and the tick on which the address half and cas_n change is compared against the expected one and two master-clock lags.

// File: rtl/vdram_mux_pkg.sv
package vdram_mux_pkg;

   // Select code = {cpu owns cycle, row phase}
   typedef enum logic [1:0] {
      SEL_VID_COL = 2'b00,
      SEL_VID_ROW = 2'b01,
      SEL_CPU_COL = 2'b10,
      SEL_CPU_ROW = 2'b11
   } mux_sel_e;

   function automatic mux_sel_e make_sel(input logic vid_cycle, input logic row_phase);
      return mux_sel_e'({~vid_cycle, row_phase});
   endfunction

endpackage

// File: rtl/vdram_strobe_delay.sv
module vdram_strobe_delay #(
   parameter int   STAGES  = 1,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("vdram_strobe_delay: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/vdram_src_map.sv
module vdram_src_map #(
   parameter int AW    = 8,
   parameter int RL_W  = 3,
   parameter int MA_W  = 13,
   parameter int CPU_W = 16
) (
   input  logic [MA_W-1:0]  crtc_ma,
   input  logic [RL_W-1:0]  raster,
   input  logic [CPU_W-1:0] cpu_addr,
   output logic [AW-1:0]    vid_row,
   output logic [AW-1:0]    vid_col,
   output logic [AW-1:0]    cpu_row,
   output logic [AW-1:0]    cpu_col
);

   localparam int MA_ROW_W = AW - RL_W;

   generate
      for (genvar b = 0; b < AW; b++) begin : g_bit
         if (b < RL_W) begin : g_raster
            assign vid_row[b] = raster[b];
         end else begin : g_ma_low
            assign vid_row[b] = crtc_ma[b - RL_W];
         end
         assign vid_col[b] = crtc_ma[MA_ROW_W + b];
         assign cpu_row[b] = cpu_addr[b];
         assign cpu_col[b] = cpu_addr[AW + b];
      end
   endgenerate

endmodule

// File: rtl/vdram_mux4_slice.sv
module vdram_mux4_slice
   import vdram_mux_pkg::*;
(
   input  mux_sel_e sel,
   input  logic     vid_row,
   input  logic     vid_col,
   input  logic     cpu_row,
   input  logic     cpu_col,
   output logic     y
);

   always_comb begin
      unique case (sel)
         SEL_VID_ROW: y = vid_row;
         SEL_VID_COL: y = vid_col;
         SEL_CPU_ROW: y = cpu_row;
         SEL_CPU_COL: y = cpu_col;
         default:     y = 1'b0;
      endcase
   end

endmodule

// File: rtl/vdram_addr_mux.sv
module vdram_addr_mux
   import vdram_mux_pkg::*;
#(
   parameter int AW         = 8,
   parameter int RL_W       = 3,
   parameter int MA_W       = 13,
   parameter int CPU_W      = 16,
   parameter int RC_STAGES  = 1,
   parameter int CAS_STAGES = 1
) (
   input  logic             clk_fast,
   input  logic             clk_half,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             vid_cyc,
   input  logic [MA_W-1:0]  crtc_ma,
   input  logic [RL_W-1:0]  raster,
   input  logic [CPU_W-1:0] cpu_addr,
   output logic [AW-1:0]    dram_addr,
   output logic             cas_n
);

   localparam int MA_NEED = 2 * AW - RL_W;

   generate
      if (RL_W < 1 || RL_W >= AW) begin : g_bad_rl
         $error("vdram_addr_mux: RL_W must lie in 1..AW-1");
      end
      if (MA_W != MA_NEED) begin : g_bad_ma
         $error("vdram_addr_mux: MA_W must equal 2*AW-RL_W");
      end
      if (CPU_W != 2 * AW) begin : g_bad_cpu
         $error("vdram_addr_mux: CPU_W must equal 2*AW");
      end
   endgenerate

   logic     row_phase;
   mux_sel_e sel;
   logic [AW-1:0] vid_row, vid_col, cpu_row, cpu_col;

   vdram_strobe_delay #(.STAGES(RC_STAGES), .RST_VAL(1'b1)) u_rc_dly (
      .clk   (clk_fast),
      .rst_n (rst_n),
      .d     (ras_n),
      .q     (row_phase)
   );

   vdram_strobe_delay #(.STAGES(CAS_STAGES), .RST_VAL(1'b1)) u_cas_dly (
      .clk   (clk_half),
      .rst_n (rst_n),
      .d     (ras_n),
      .q     (cas_n)
   );

   vdram_src_map #(.AW(AW), .RL_W(RL_W), .MA_W(MA_W), .CPU_W(CPU_W)) u_map (
      .crtc_ma  (crtc_ma),
      .raster   (raster),
      .cpu_addr (cpu_addr),
      .vid_row  (vid_row),
      .vid_col  (vid_col),
      .cpu_row  (cpu_row),
      .cpu_col  (cpu_col)
   );

   assign sel = make_sel(vid_cyc, row_phase);

   generate
      for (genvar b = 0; b < AW; b++) begin : g_slice
         vdram_mux4_slice u_slice (
            .sel     (sel),
            .vid_row (vid_row[b]),
            .vid_col (vid_col[b]),
            .cpu_row (cpu_row[b]),
            .cpu_col (cpu_col[b]),
            .y       (dram_addr[b])
         );
      end
   endgenerate

endmodule

// File: rtl/vdram_addr_mux_chk.sv
module vdram_addr_mux_chk #(
   parameter int AW    = 8,
   parameter int RL_W  = 3,
   parameter int MA_W  = 13,
   parameter int CPU_W = 16
) (
   input logic             clk_fast,
   input logic             rst_n,
   input logic             ras_n,
   input logic             vid_cyc,
   input logic [MA_W-1:0]  crtc_ma,
   input logic [RL_W-1:0]  raster,
   input logic [CPU_W-1:0] cpu_addr,
   input logic [AW-1:0]    dram_addr,
   input logic             cas_n
);

   localparam int MA_ROW_W = AW - RL_W;

   logic [AW-1:0] want_row, want_col;
   assign want_row = vid_cyc ? {crtc_ma[MA_ROW_W-1:0], raster} : cpu_addr[AW-1:0];
   assign want_col = vid_cyc ? crtc_ma[MA_ROW_W +: AW]        : cpu_addr[AW +: AW];

   // R10 / R2 / R4: precharge presents the row half
   p_row_in_precharge_r10: assert property (@(posedge clk_fast) disable iff (!rst_n)
      ras_n |=> (dram_addr == want_row));

   // R7 / R3 / R5: strobe low one tick ago gives the column half
   p_col_after_ras_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !ras_n |=> (dram_addr == want_col));

   // R8: strobe low over two master ticks has crossed a half-rate edge
   p_cas_follows_r8: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (!ras_n && !$past(ras_n) && $past(rst_n)) |=> !cas_n);

   // R9: strobe high over two master ticks has released the column strobe
   p_cas_release_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (ras_n && $past(ras_n) && $past(rst_n)) |=> cas_n);

endmodule

bind vdram_addr_mux vdram_addr_mux_chk #(
   .AW(AW), .RL_W(RL_W), .MA_W(MA_W), .CPU_W(CPU_W)
) u_chk (
   .clk_fast  (clk_fast),
   .rst_n     (rst_n),
   .ras_n     (ras_n),
   .vid_cyc   (vid_cyc),
   .crtc_ma   (crtc_ma),
   .raster    (raster),
   .cpu_addr  (cpu_addr),
   .dram_addr (dram_addr),
   .cas_n     (cas_n)
);

// File: tb/vdram_addr_mux_tb.sv
`timescale 1ns/100ps
module vdram_addr_mux_tb;

   logic        clk_fast = 1'b0;
   logic        clk_half = 1'b0;
   logic        rst_n    = 1'b0;
   logic        ras_n    = 1'b0;
   logic        vid_cyc  = 1'b0;
   logic [12:0] crtc_ma  = '0;
   logic [2:0]  raster   = '0;
   logic [15:0] cpu_addr = '0;
   wire  [7:0]  dram_addr;
   wire         cas_n;

   vdram_addr_mux u_dut (
      .clk_fast  (clk_fast),
      .clk_half  (clk_half),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .vid_cyc   (vid_cyc),
      .crtc_ma   (crtc_ma),
      .raster    (raster),
      .cpu_addr  (cpu_addr),
      .dram_addr (dram_addr),
      .cas_n     (cas_n)
   );

   // 200 MHz master clock; half-rate rising edges on odd master edges
   always #2.5 clk_fast = ~clk_fast;
   initial begin
      #2.5;
      forever begin
         clk_half = ~clk_half;
         #5;
      end
   end

   int cyc = 0;
   always @(posedge clk_fast) cyc <= cyc + 1;

   typedef struct {
      int         due;
      logic [7:0] addr;
      logic       cas;
      string      req;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit col_ph = 1'b0;
   bit cas_e  = 1'b1;

   function automatic logic [7:0] spec_addr(input bit col);
      if (vid_cyc) return col ? crtc_ma[12:5] : {crtc_ma[4:0], raster};
      else         return col ? cpu_addr[15:8] : cpu_addr[7:0];
   endfunction

   task automatic push(input int due, input bit col, input logic cas, input string req);
      item_t it;
      it.due  = due;
      it.addr = spec_addr(col);
      it.cas  = cas;
      it.req  = req;
      q.push_back(it);
   endtask

   task automatic step();
      @(posedge clk_fast);
      #1;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk_fast);
   endtask

   task automatic align(input int parity);
      step();
      while ((cyc % 2) != parity) step();
   endtask

   task automatic set_src(input logic [12:0] ma, input logic [2:0] rl,
                          input logic [15:0] cpu, input logic vid, input string req);
      step();
      crtc_ma  = ma;
      raster   = rl;
      cpu_addr = cpu;
      vid_cyc  = vid;
      push(cyc, col_ph, cas_e, req);
      drain();
   endtask

   // odd parity: a half-rate edge has just passed
   task automatic ras_fall(input int parity);
      align(parity);
      ras_n = 1'b0;
      push(cyc, 1'b0, 1'b1, "R10 row before strobe sampled");
      if (parity == 1) begin
         push(cyc + 1, 1'b1, 1'b1, "R7 column after 1 tick, R8 cas still high");
         push(cyc + 2, 1'b1, 1'b0, "R8 cas low after 2 ticks");
      end else begin
         push(cyc + 1, 1'b1, 1'b0, "R7 column and R8 cas low after 1 tick");
      end
      col_ph = 1'b1;
      cas_e  = 1'b0;
      drain();
   endtask

   task automatic ras_rise(input int parity);
      align(parity);
      ras_n = 1'b1;
      push(cyc, 1'b1, 1'b0, "R7 column before strobe sampled");
      if (parity == 1) begin
         push(cyc + 1, 1'b0, 1'b0, "R10 row after 1 tick, R9 cas still low");
         push(cyc + 2, 1'b0, 1'b1, "R9 cas high after 2 ticks");
      end else begin
         push(cyc + 1, 1'b0, 1'b1, "R9 row and cas high after 1 tick");
      end
      col_ph = 1'b0;
      cas_e  = 1'b1;
      drain();
   endtask

   // monitor: pop and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk_fast);
         while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.due != cyc || dram_addr !== it.addr || cas_n !== it.cas) begin
               fails++;
               $display("FAIL %s: addr=%h cas=%b, expected addr=%h cas=%b (tick %0d, due %0d)",
                        it.req, dram_addr, cas_n, it.addr, it.cas, cyc, it.due);
            end
         end
      end
   end

   bit done = 1'b0;

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset holds row phase and cas high while the strobe is low
      step(); step(); step();
      cpu_addr = 16'hC3A5;
      push(cyc, 1'b0, 1'b1, "R1 reset state");
      drain();
      step();
      vid_cyc = 1'b1;
      crtc_ma = 13'h1ABC;
      raster  = 3'd5;
      push(cyc, 1'b0, 1'b1, "R1 reset state video");
      drain();
      ras_n = 1'b1;
      step(); step();
      rst_n = 1'b1;
      step(); step();

      // CPU row half (R4), walking one over every CPU bit
      for (int i = 0; i < 16; i++)
         set_src(13'h0, 3'd0, 16'h1 << i, 1'b0, "R4 cpu row walking one");
      set_src(13'h0, 3'd0, 16'hA55A, 1'b0, "R4 cpu row mixed");

      // video row half (R2)
      for (int i = 0; i < 13; i++)
         set_src(13'h1 << i, 3'd0, 16'h0, 1'b1, "R2 video row ma walking one");
      for (int i = 0; i < 3; i++)
         set_src(13'h0, 3'd1 << i, 16'h0, 1'b1, "R2 video row raster walking one");
      set_src(13'h15A3, 3'd6, 16'h0, 1'b1, "R2 video row mixed");

      // R6: owner switch takes effect in the same cycle, row phase
      set_src(13'h0B6E, 3'd3, 16'h5CF1, 1'b0, "R6 switch to cpu row");
      set_src(13'h0B6E, 3'd3, 16'h5CF1, 1'b1, "R6 switch to video row");

      // strobe falls just after a half-rate edge
      ras_fall(1);

      // CPU column half (R5)
      for (int i = 0; i < 16; i++)
         set_src(13'h0, 3'd7, 16'h1 << i, 1'b0, "R5 cpu column walking one");
      set_src(13'h0, 3'd0, 16'h3CC3, 1'b0, "R5 cpu column mixed");

      // video column half (R3)
      for (int i = 0; i < 13; i++)
         set_src(13'h1 << i, 3'd7, 16'h0, 1'b1, "R3 video column ma walking one");
      set_src(13'h0000, 3'd7, 16'hFFFF, 1'b1, "R3 video column raster ignored");
      set_src(13'h0F0F, 3'd2, 16'h0, 1'b1, "R3 video column mixed");

      // R6 in column phase
      set_src(13'h1E2D, 3'd4, 16'h96E1, 1'b0, "R6 switch to cpu column");
      set_src(13'h1E2D, 3'd4, 16'h96E1, 1'b1, "R6 switch to video column");

      // strobe rises just after a half-rate edge, then at the other phase
      ras_rise(1);
      set_src(13'h1E2D, 3'd4, 16'h96E1, 1'b0, "R10 cpu row in precharge");
      ras_fall(0);
      set_src(13'h0777, 3'd1, 16'h4BB4, 1'b0, "R5 cpu column after second strobe");
      ras_rise(0);
      set_src(13'h0777, 3'd1, 16'h4BB4, 1'b1, "R10 video row in precharge");

      drain();
      step(); step();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule